// File: doc/BRIEF.md
# Pseudo-static RAM power-up and deep-sleep sequencer

This block sits on the controller side of an octal double-data-rate pseudo-static RAM. It takes the memory from power-on to a usable state, and it moves the memory into and out of deep power-down. It owns the chip-select, active-low reset and clock-gate outputs while a sequence runs. During a command frame it also presents one byte per system clock on a byte lane, which a PHY outside this block serializes.

Every wait is a cycle count. Each count is derived at elaboration time from a clock-frequency parameter in kHz and a nanosecond value per interval, rounded up, with a minimum of one cycle. The first phase of initialization is a supply-settling wait. The second phase is selected by an input: either a pulse on the reset pin, or a global-reset command frame. The upper layer then sees `ready_o`. It may ask for deep power-down once a minimum spacing interval has elapsed. Sleep is left in one of two ways: a short chip-select pulse, or a reset-pin pulse. The reset-pin exit flags that the mode register must be reprogrammed.

Top module: `psram_pwr_seq`

## Requirements
- R1: While reset is asserted the outputs are `ce_n_o`=1, `reset_n_o`=1, `clk_en_o`=0, `dq_oe_o`=0, `ready_o`=0, `busy_o`=1, `in_dpd_o`=0 and `mr_reprog_o`=0.
- R2: After reset release, chip select and the reset pin both stay high and the clock gate stays low for at least the settling count (150 µs) before the second phase starts.
- R3: With `init_sel_i`=0, `reset_n_o` goes low for exactly the pulse count (1 µs), with `ce_n_o` high before and during the pulse. `ready_o` rises exactly the recovery count (2 µs) after `reset_n_o` returns high.
- R4: With `init_sel_i`=1, `ce_n_o` is low for exactly 4 cycles. During those cycles `clk_en_o`=1, `dq_oe_o`=1 and `dq_o`=8'hFF. `reset_n_o` stays high, and `ready_o` rises exactly the recovery count (2 µs) after `ce_n_o` returns high.
- R5: `ready_o` and `busy_o` are never both high. A sleep-exit request given while a timed interval runs is ignored.
- R6: A sleep request is acted on only after `ready_o` has been high for the spacing count (500 µs) since initialization finished. With the request held high, `ready_o` stays high for exactly that count plus one cycle. A request pulse given earlier is ignored.
- R7: Sleep entry drives `ce_n_o` low for exactly 8 cycles with `clk_en_o`=1. `dq_o` carries, in order, 40h, 40h, 00h, 04h, 00h, 00h, {1'b0, `mode_cfg_i[14:8]`}, `mode_cfg_i[7:0]`. The cleared top bit of the seventh byte is the power-down request bit.
- R8: After the entry frame, `ce_n_o` stays high with `busy_o`=1 for exactly the sleep-hold count (500 µs). After that `in_dpd_o`=1, `busy_o`=0 and `ready_o`=0, and while `in_dpd_o`=1 the clock gate is low.
- R9: A sleep-exit request with `exit_sel_i`=0 drives `ce_n_o` low for the exit-pulse count (60 ns, at least one cycle) with the clock gate low. `ready_o` rises exactly the wake count (150 µs) after `ce_n_o` returns high, and `mr_reprog_o` stays 0.
- R10: A sleep-exit request with `exit_sel_i`=1 pulses `reset_n_o` low for the pulse count, with `ce_n_o` high throughout. `ready_o` rises exactly the wake count (150 µs) after the pulse, and `mr_reprog_o` is 1 from then on.
- R11: `mr_reprog_o` holds at 1 until `mr_done_i` is seen while ready, and it reads 0 two clocks after that pulse.
- R12: After any sleep exit, the spacing count of R6 restarts from the rise of `ready_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| init_sel_i | input | 1 | Second-phase method: 0 reset pin, 1 global-reset frame |
| dpd_enter_i | input | 1 | Request to enter deep power-down |
| dpd_exit_i | input | 1 | Request to leave deep power-down |
| exit_sel_i | input | 1 | Exit method: 0 chip-select pulse, 1 reset-pin pulse |
| mode_cfg_i | input | 15 | Mode register bits 14..0 written with the sleep request |
| mr_done_i | input | 1 | Upper layer has reprogrammed the mode register |
| ce_n_o | output | 1 | Chip select to memory, active low |
| reset_n_o | output | 1 | Reset pin to memory, active low |
| clk_en_o | output | 1 | Memory clock gate |
| dq_o | output | 8 | Command byte for the current cycle |
| dq_oe_o | output | 1 | Byte lane drive enable |
| ready_o | output | 1 | Memory usable for transfers |
| busy_o | output | 1 | A timed interval or frame is running |
| in_dpd_o | output | 1 | Memory is in or entering deep power-down |
| mr_reprog_o | output | 1 | Mode register is back at defaults and needs rewriting |

## Verification
The properties assume that the clock really runs at the frequency given by `CLK_KHZ`. They also assume that `mode_cfg_i` and `exit_sel_i` are stable whenever the block samples them, and that `mr_done_i` is only raised while the block is ready. The stimulus changes inputs only on falling clock edges. It sets the method selects before the request they qualify, and it holds the configuration constant for the whole run. Requests arriving while a timed interval runs are legal input, so the bench deliberately sends one during the sleep hold, and another before the spacing interval has elapsed.

// File: rtl/psram_seq_pkg.sv
package psram_seq_pkg;

  typedef enum logic [3:0] {
    ST_PU,
    ST_CHR,
    ST_RST_LOW,
    ST_RST_REC,
    ST_GR_FRAME,
    ST_IDLE,
    ST_DPD_FRAME,
    ST_DPD_HOLD,
    ST_DPD,
    ST_XCE_LOW,
    ST_XCE_WAIT
  } seq_state_e;

  typedef struct packed {
    logic       ce_n;
    logic       reset_n;
    logic       clk_en;
    logic       dq_oe;
    logic [7:0] dq;
    logic       ready;
    logic       busy;
    logic       in_dpd;
  } pin_s;

  localparam logic [7:0] CMD_GLOBAL_RST = 8'hFF;
  localparam logic [7:0] CMD_REG_WRITE  = 8'h40;
  localparam logic [7:0] MODE_REG_ADDR  = 8'h04;
  localparam int unsigned FRAME_LEN     = 8;

  // Round a nanosecond interval up to whole clocks, never below one.
  function automatic int unsigned ns2cyc(input longint unsigned ns,
                                         input longint unsigned khz);
    longint unsigned c;
    c = (ns * khz + 64'd999999) / 64'd1000000;
    if (c == 64'd0) c = 64'd1;
    return c[31:0];
  endfunction

  function automatic int unsigned cmax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/psram_seq_rsync.sv
module psram_seq_rsync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic srst_no
);
  logic [STAGES-1:0] sync_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[g] <= 1'b0;
        else if (g == 0) sync_q[g] <= 1'b1;
        else sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign srst_no = sync_q[STAGES-1];
endmodule

// File: rtl/psram_seq_timer.sv
module psram_seq_timer #(
  parameter int          W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic [2:0]   lsb_o,
  output logic         done_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = load_i || (cnt_q != '0);

  always_comb begin
    if (load_i) cnt_d = val_i;
    else        cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= RST_VAL;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done_o = (cnt_q == '0);
  assign lsb_o  = cnt_q[2:0];
endmodule

// File: rtl/psram_seq_gap.sv
module psram_seq_gap #(
  parameter int GAP = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic ok_o
);
  localparam int GW = $clog2(GAP + 1);
  localparam logic [GW-1:0] GAP_V = GW'(GAP);

  logic [GW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = restart_i || (cnt_q != GAP_V);
  assign cnt_d  = restart_i ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign ok_o = (cnt_q == GAP_V);
endmodule

// File: rtl/psram_seq_frame.sv
module psram_seq_frame
  import psram_seq_pkg::*;
(
  input  logic [2:0]  idx_i,
  input  logic [14:0] cfg_i,
  output logic [7:0]  byte_o
);
  // Byte order on the lane is fixed by the memory's command decoder.
  always_comb begin
    unique case (idx_i)
      3'd0, 3'd1: byte_o = CMD_REG_WRITE;
      3'd3:       byte_o = MODE_REG_ADDR;
      3'd6:       byte_o = {1'b0, cfg_i[14:8]};
      3'd7:       byte_o = cfg_i[7:0];
      default:    byte_o = 8'h00;
    endcase
  end
endmodule

// File: rtl/psram_pwr_seq.sv
module psram_pwr_seq
  import psram_seq_pkg::*;
#(
  parameter int unsigned CLK_KHZ    = 100000,
  parameter int unsigned T_PU_NS    = 150000,
  parameter int unsigned T_RP_NS    = 1000,
  parameter int unsigned T_RST_NS   = 2000,
  parameter int unsigned T_CHR_NS   = 20,
  parameter int unsigned T_DPD_NS   = 500000,
  parameter int unsigned T_DPDP_NS  = 500000,
  parameter int unsigned T_XPD_NS   = 60,
  parameter int unsigned T_XDPD_NS  = 150000,
  parameter int unsigned T_RCH_NS   = 150000,
  parameter int unsigned GR_LEN     = 4,
  parameter int          SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        init_sel_i,
  input  logic        dpd_enter_i,
  input  logic        dpd_exit_i,
  input  logic        exit_sel_i,
  input  logic [14:0] mode_cfg_i,
  input  logic        mr_done_i,
  output logic        ce_n_o,
  output logic        reset_n_o,
  output logic        clk_en_o,
  output logic [7:0]  dq_o,
  output logic        dq_oe_o,
  output logic        ready_o,
  output logic        busy_o,
  output logic        in_dpd_o,
  output logic        mr_reprog_o
);
  localparam int unsigned PU_CYC   = ns2cyc(T_PU_NS,   CLK_KHZ);
  localparam int unsigned RP_CYC   = ns2cyc(T_RP_NS,   CLK_KHZ);
  localparam int unsigned RST_CYC  = ns2cyc(T_RST_NS,  CLK_KHZ);
  localparam int unsigned CHR_CYC  = ns2cyc(T_CHR_NS,  CLK_KHZ);
  localparam int unsigned DPD_CYC  = ns2cyc(T_DPD_NS,  CLK_KHZ);
  localparam int unsigned DPDP_CYC = ns2cyc(T_DPDP_NS, CLK_KHZ);
  localparam int unsigned XPD_CYC  = ns2cyc(T_XPD_NS,  CLK_KHZ);
  localparam int unsigned XDPD_CYC = ns2cyc(T_XDPD_NS, CLK_KHZ);
  localparam int unsigned RCH_CYC  = ns2cyc(T_RCH_NS,  CLK_KHZ);
  localparam int unsigned TMAX = cmax(cmax(cmax(PU_CYC, DPD_CYC), cmax(XDPD_CYC, RCH_CYC)),
                                      cmax(cmax(RP_CYC, RST_CYC),
                                           cmax(cmax(CHR_CYC, XPD_CYC), cmax(FRAME_LEN, GR_LEN))));
  localparam int TW = $clog2(TMAX + 1);

  logic          srst_n;
  seq_state_e    state_q, state_d;
  logic          ld;
  logic [TW-1:0] ld_val;
  logic [2:0]    t_lsb;
  logic          t_done;
  logic          gap_rst, gap_ok;
  logic          rexit_q, rexit_d;
  logic          reprog_q, reprog_d;
  logic [2:0]    f_idx;
  logic [7:0]    f_byte;
  pin_s          pins_d, pins_q;

  psram_seq_rsync #(.STAGES(SYNC_STAGES)) u_rsync (
    .clk_i(clk_i), .rst_ni(rst_ni), .srst_no(srst_n)
  );

  psram_seq_timer #(.W(TW), .RST_VAL(TW'(PU_CYC - 1))) u_timer (
    .clk_i(clk_i), .rst_ni(srst_n), .load_i(ld), .val_i(ld_val),
    .lsb_o(t_lsb), .done_o(t_done)
  );

  psram_seq_gap #(.GAP(DPDP_CYC)) u_gap (
    .clk_i(clk_i), .rst_ni(srst_n), .restart_i(gap_rst), .ok_o(gap_ok)
  );

  assign f_idx = 3'(FRAME_LEN - 1) - t_lsb;

  psram_seq_frame u_frame (
    .idx_i(f_idx), .cfg_i(mode_cfg_i), .byte_o(f_byte)
  );

  // Next-state logic.
  always_comb begin
    state_d  = state_q;
    ld       = 1'b0;
    ld_val   = '0;
    gap_rst  = 1'b0;
    rexit_d  = rexit_q;
    reprog_d = reprog_q;
    if (state_q == ST_IDLE && mr_done_i) reprog_d = 1'b0;
    unique case (state_q)
      ST_PU: if (t_done) begin
        ld = 1'b1;
        if (init_sel_i) begin
          state_d = ST_GR_FRAME;
          ld_val  = TW'(GR_LEN - 1);
        end else begin
          state_d = ST_CHR;
          ld_val  = TW'(CHR_CYC - 1);
        end
      end
      ST_CHR: if (t_done) begin
        state_d = ST_RST_LOW;
        ld      = 1'b1;
        ld_val  = TW'(RP_CYC - 1);
      end
      ST_RST_LOW: if (t_done) begin
        state_d = ST_RST_REC;
        ld      = 1'b1;
        ld_val  = rexit_q ? TW'(RCH_CYC - 1) : TW'(RST_CYC - 1);
      end
      ST_GR_FRAME: if (t_done) begin
        state_d = ST_RST_REC;
        ld      = 1'b1;
        ld_val  = TW'(RST_CYC - 1);
      end
      ST_RST_REC: if (t_done) begin
        state_d = ST_IDLE;
        gap_rst = 1'b1;
        if (rexit_q) reprog_d = 1'b1;
        rexit_d = 1'b0;
      end
      ST_IDLE: if (dpd_enter_i && gap_ok) begin
        state_d = ST_DPD_FRAME;
        ld      = 1'b1;
        ld_val  = TW'(FRAME_LEN - 1);
      end
      ST_DPD_FRAME: if (t_done) begin
        state_d = ST_DPD_HOLD;
        ld      = 1'b1;
        ld_val  = TW'(DPD_CYC - 1);
      end
      ST_DPD_HOLD: if (t_done) state_d = ST_DPD;
      ST_DPD: if (dpd_exit_i) begin
        ld = 1'b1;
        if (exit_sel_i) begin
          state_d = ST_CHR;
          ld_val  = TW'(CHR_CYC - 1);
          rexit_d = 1'b1;
        end else begin
          state_d = ST_XCE_LOW;
          ld_val  = TW'(XPD_CYC - 1);
        end
      end
      ST_XCE_LOW: if (t_done) begin
        state_d = ST_XCE_WAIT;
        ld      = 1'b1;
        ld_val  = TW'(XDPD_CYC - 1);
      end
      ST_XCE_WAIT: if (t_done) begin
        state_d = ST_IDLE;
        gap_rst = 1'b1;
      end
      default: state_d = ST_PU;
    endcase
  end

  // Pin decode from the current state; registered below.
  always_comb begin
    pins_d         = '0;
    pins_d.ce_n    = 1'b1;
    pins_d.reset_n = 1'b1;
    pins_d.busy    = 1'b1;
    unique case (state_q)
      ST_RST_LOW: pins_d.reset_n = 1'b0;
      ST_GR_FRAME: begin
        pins_d.ce_n   = 1'b0;
        pins_d.clk_en = 1'b1;
        pins_d.dq_oe  = 1'b1;
        pins_d.dq     = CMD_GLOBAL_RST;
      end
      ST_IDLE: begin
        pins_d.ready = 1'b1;
        pins_d.busy  = 1'b0;
      end
      ST_DPD_FRAME: begin
        pins_d.ce_n   = 1'b0;
        pins_d.clk_en = 1'b1;
        pins_d.dq_oe  = 1'b1;
        pins_d.dq     = f_byte;
      end
      ST_DPD_HOLD: pins_d.in_dpd = 1'b1;
      ST_DPD: begin
        pins_d.in_dpd = 1'b1;
        pins_d.busy   = 1'b0;
      end
      ST_XCE_LOW: pins_d.ce_n = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge srst_n) begin
    if (!srst_n) begin
      state_q        <= ST_PU;
      rexit_q        <= 1'b0;
      reprog_q       <= 1'b0;
      pins_q         <= '0;
      pins_q.ce_n    <= 1'b1;
      pins_q.reset_n <= 1'b1;
      pins_q.busy    <= 1'b1;
    end else begin
      state_q  <= state_d;
      rexit_q  <= rexit_d;
      reprog_q <= reprog_d;
      pins_q   <= pins_d;
    end
  end

  assign ce_n_o      = pins_q.ce_n;
  assign reset_n_o   = pins_q.reset_n;
  assign clk_en_o    = pins_q.clk_en;
  assign dq_o        = pins_q.dq;
  assign dq_oe_o     = pins_q.dq_oe;
  assign ready_o     = pins_q.ready;
  assign busy_o      = pins_q.busy;
  assign in_dpd_o    = pins_q.in_dpd;
  assign mr_reprog_o = reprog_q;
endmodule

// File: rtl/psram_pwr_seq_chk.sv
module psram_pwr_seq_chk #(
  parameter int PU_C   = 16,
  parameter int DPDP_C = 16,
  parameter int DPD_C  = 16
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ce_n_o,
  input logic       reset_n_o,
  input logic       clk_en_o,
  input logic [7:0] dq_o,
  input logic       dq_oe_o,
  input logic       ready_o,
  input logic       busy_o,
  input logic       in_dpd_o,
  input logic       mr_reprog_o
);
  int since_q, rdy_run_q, dpd_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q   <= 0;
      rdy_run_q <= 0;
      dpd_run_q <= 0;
    end else begin
      if (since_q <= PU_C) since_q <= since_q + 1;
      if (!ready_o) rdy_run_q <= 0;
      else if (rdy_run_q <= DPDP_C) rdy_run_q <= rdy_run_q + 1;
      if (!in_dpd_o) dpd_run_q <= 0;
      else if (dpd_run_q <= DPD_C) dpd_run_q <= dpd_run_q + 1;
    end
  end

  assert_phase1_wait_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_n_o || !reset_n_o) |-> (since_q >= PU_C)) else $error("phase-1 wait cut short");

  assert_cs_high_at_reset_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(reset_n_o) |-> (ce_n_o && $past(ce_n_o))) else $error("chip select low around reset pulse");

  assert_ready_not_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (!busy_o && !in_dpd_o)) else $error("ready overlaps busy or sleep");

  assert_gap_before_entry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ready_o) && !ce_n_o) |-> (rdy_run_q >= DPDP_C)) else $error("sleep entered too early");

  assert_frame_clocked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_n_o && dq_oe_o) |-> clk_en_o) else $error("frame byte without clock");

  assert_sleep_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_dpd_o |-> (ce_n_o && reset_n_o && !clk_en_o && !dq_oe_o)) else $error("pins active in sleep");

  assert_sleep_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(in_dpd_o) |-> (dpd_run_q >= DPD_C)) else $error("sleep left before hold time");

  assert_reprog_then_ready_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mr_reprog_o) |=> ready_o) else $error("reprogram flag without ready");

  assert_lane_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_n_o |-> (!dq_oe_o && dq_o == 8'h00)) else $error("lane driven while deselected");
endmodule

bind psram_pwr_seq psram_pwr_seq_chk #(
  .PU_C(PU_CYC), .DPDP_C(DPDP_CYC), .DPD_C(DPD_CYC)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ce_n_o(ce_n_o), .reset_n_o(reset_n_o),
  .clk_en_o(clk_en_o), .dq_o(dq_o), .dq_oe_o(dq_oe_o), .ready_o(ready_o),
  .busy_o(busy_o), .in_dpd_o(in_dpd_o), .mr_reprog_o(mr_reprog_o)
);

// File: tb/psram_pwr_seq_tb.sv
module psram_pwr_seq_tb;
  // Timing at CLK_KHZ = 10000: cycles = ceil(ns / 100).
  localparam int PU_C   = 1500;
  localparam int RP_C   = 10;
  localparam int RST_C  = 20;
  localparam int DPD_C  = 5000;
  localparam int DPDP_C = 5000;
  localparam int XP_C   = 1;
  localparam int XD_C   = 1500;
  localparam int RCH_C  = 1500;
  localparam int GR_C   = 4;
  localparam logic [14:0] CFG = 15'h6B5C;
  // Rows: {init_sel, exit_sel, expected reprogram flag after exit}
  localparam logic [2:0] VEC [4] = '{3'b000, 3'b011, 3'b100, 3'b111};

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, init_sel, dpd_enter, dpd_exit, exit_sel, mr_done;
  logic [14:0] mode_cfg;
  logic ce_n, reset_n, clk_en, dq_oe, ready, busy, in_dpd, mr_reprog;
  logic [7:0] dq;
  int total = 0;
  int bad = 0;

  psram_pwr_seq #(.CLK_KHZ(10000)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .init_sel_i(init_sel), .dpd_enter_i(dpd_enter),
    .dpd_exit_i(dpd_exit), .exit_sel_i(exit_sel), .mode_cfg_i(mode_cfg),
    .mr_done_i(mr_done), .ce_n_o(ce_n), .reset_n_o(reset_n), .clk_en_o(clk_en),
    .dq_o(dq), .dq_oe_o(dq_oe), .ready_o(ready), .busy_o(busy),
    .in_dpd_o(in_dpd), .mr_reprog_o(mr_reprog)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic sig(input int s);
    case (s)
      0: return ce_n;
      1: return reset_n;
      2: return ready;
      default: return busy;
    endcase
  endfunction

  task automatic run_len(input int s, input logic v, output int n);
    n = 0;
    while (sig(s) == v && n < 20000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic wait_for(input int s, input logic v);
    while (sig(s) != v) @(negedge clk);
  endtask

  function automatic logic [7:0] fbyte(input int i);
    case (i)
      0, 1: return 8'h40;
      3: return 8'h04;
      6: return {1'b0, CFG[14:8]};
      7: return CFG[7:0];
      default: return 8'h00;
    endcase
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; dpd_enter = 1'b0; dpd_exit = 1'b0; mr_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_init(input logic isel);
    int n;
    bit cbad;
    bit fbad;
    init_sel = isel;
    n = 0; cbad = 0;
    while (ce_n && reset_n && n < 5000) begin
      if (clk_en) cbad = 1;
      n++;
      @(negedge clk);
    end
    chk(n >= PU_C && n <= PU_C + 5, "R2 phase-1 length", n, PU_C);
    chk(!cbad, "R2 clock gate in phase 1", int'(cbad), 0);
    if (!isel) begin
      chk(ce_n == 1'b1, "R3 chip select during reset", int'(ce_n), 1);
      run_len(1, 1'b0, n);
      chk(n == RP_C, "R3 reset pulse", n, RP_C);
      run_len(2, 1'b0, n);
      chk(n == RST_C, "R3 recovery", n, RST_C);
    end else begin
      n = 0; fbad = 0;
      while (!ce_n && n < 100) begin
        if (dq !== 8'hFF || !dq_oe || !clk_en || !reset_n) fbad = 1;
        n++;
        @(negedge clk);
      end
      chk(n == GR_C, "R4 frame length", n, GR_C);
      chk(!fbad, "R4 frame content", int'(fbad), 0);
      run_len(2, 1'b0, n);
      chk(n == RST_C, "R4 recovery", n, RST_C);
    end
  endtask

  task automatic do_enter(input string req, input bit probe, input int exp_gap);
    int n;
    int idx;
    bit fbad;
    dpd_enter = 1'b1;
    run_len(2, 1'b1, n);
    chk(n == exp_gap, req, n, exp_gap);
    idx = 0; fbad = 0;
    while (!ce_n && idx < 100) begin
      if (dq !== fbyte(idx) || !clk_en || !dq_oe) fbad = 1;
      idx++;
      @(negedge clk);
    end
    dpd_enter = 1'b0;
    chk(idx == 8, "R7 frame length", idx, 8);
    chk(!fbad, "R7 frame bytes", int'(fbad), 0);
    n = 0;
    if (probe) begin
      exit_sel = 1'b0;
      dpd_exit = 1'b1;
    end
    while (busy && ce_n && n < 20000) begin
      n++;
      @(negedge clk);
      dpd_exit = 1'b0;
    end
    chk(n == DPD_C, "R8 hold length", n, DPD_C);
    chk(in_dpd && !ready && !busy, "R8 sleep flags", int'({in_dpd, ready, busy}), 4);
    if (probe) begin
      repeat (20) @(negedge clk);
      chk(in_dpd && ce_n && reset_n, "R5 exit during hold ignored", int'(in_dpd), 1);
    end
  endtask

  task automatic do_exit(input logic esel, input logic exp_rp);
    int n;
    exit_sel = esel;
    dpd_exit = 1'b1;
    @(negedge clk);
    dpd_exit = 1'b0;
    if (!esel) begin
      wait_for(0, 1'b0);
      chk(!clk_en, "R9 clock gate in pulse", int'(clk_en), 0);
      run_len(0, 1'b0, n);
      chk(n == XP_C, "R9 exit pulse", n, XP_C);
      run_len(2, 1'b0, n);
      chk(n == XD_C, "R9 wake wait", n, XD_C);
      chk(mr_reprog == exp_rp, "R9 reprogram flag", int'(mr_reprog), int'(exp_rp));
    end else begin
      wait_for(1, 1'b0);
      chk(ce_n == 1'b1, "R10 chip select high", int'(ce_n), 1);
      run_len(1, 1'b0, n);
      chk(n == RP_C, "R10 reset pulse", n, RP_C);
      run_len(2, 1'b0, n);
      chk(n == RCH_C, "R10 wake wait", n, RCH_C);
      chk(mr_reprog == exp_rp, "R10 reprogram flag", int'(mr_reprog), int'(exp_rp));
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; init_sel = 1'b0; dpd_enter = 1'b0; dpd_exit = 1'b0;
    exit_sel = 1'b0; mr_done = 1'b0; mode_cfg = CFG;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(ce_n && reset_n && !clk_en && !dq_oe && !ready && busy && !in_dpd && !mr_reprog,
        "R1 reset outputs", int'({ce_n, reset_n, clk_en, dq_oe, ready, busy, in_dpd, mr_reprog}),
        8'b1100_0100);
    rst_n = 1'b1;

    for (int i = 0; i < 4; i++) begin
      if (i > 0) do_reset();
      do_init(VEC[i][2]);
      do_enter("R6 spacing after init", 1'b0, DPDP_C + 1);
      do_exit(VEC[i][1], VEC[i][0]);
      do_enter("R12 spacing after exit", 1'b0, DPDP_C + 1);
    end

    // Early request and exit during hold are both ignored (R6, R5).
    do_reset();
    do_init(1'b1);
    @(negedge clk); dpd_enter = 1'b1;
    @(negedge clk); dpd_enter = 1'b0;
    repeat (10) @(negedge clk);
    chk(ce_n && ready, "R6 early request ignored", int'({ce_n, ready}), 3);
    do_enter("R6 remaining spacing", 1'b1, DPDP_C + 1 - 12);

    // R11: reprogram flag held until acknowledged.
    do_reset();
    do_init(1'b0);
    do_enter("R6 spacing after init", 1'b0, DPDP_C + 1);
    do_exit(1'b1, 1'b1);
    repeat (10) @(negedge clk);
    chk(mr_reprog == 1'b1, "R11 flag held", int'(mr_reprog), 1);
    mr_done = 1'b1;
    @(negedge clk);
    mr_done = 1'b0;
    @(negedge clk);
    chk(mr_reprog == 1'b0, "R11 flag cleared", int'(mr_reprog), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule